// File: doc/BRIEF.md
# Converter Data-Ready Resynchronization Sequencer

This block generates the timing for the digital side of a decimating converter. It counts master clock cycles and marks each new output word with a one-cycle strobe. It gates the clock to the modulator and filter during low-power standby. A rising edge on the sync input resets the filter and realigns the word phase, so that several converters driven by one sync line deliver their words on the same cycle.

After a standby release or an accepted sync edge, the block holds the data-ready output at its not-ready level for a fixed settling window. The first move of data-ready to its ready level marks the first valid word. After that, data-ready pulses to the ready level once per word.

The levels of data-ready depend on the interface mode. Standby is requested from a dedicated pin in serial mode and from a configuration bit in parallel mode.

Top module: `cvr_ready_seq`

## Requirements
- R1: `word_strobe` is a one-cycle pulse that repeats every WORD_LEN cycles while the block is active. The first strobe comes WORD_LEN cycles after the word phase restarts.
- R2: When `mode_serial`=1, standby follows `standby_pin` and `standby_cfg` is ignored. When `mode_serial`=0, standby follows `standby_cfg` and `standby_pin` is ignored.
- R3: A standby request sampled on a clock edge drives `clk_en` to 0 from that edge onward. During standby, no `word_strobe` is produced. `clk_en` returns to 1 on the first edge that samples the request low.
- R4: `data_ready` idles at 1 in parallel mode (`mode_serial`=0) and at 0 in serial mode (`mode_serial`=1). Its ready level is the opposite value. It stays at the idle level throughout standby.
- R5: `sync_in` passes through a SYNC_FLOPS-deep sampling chain. The edge that detects a rise produces a one-cycle `filter_rst` pulse SYNC_FLOPS cycles after the first edge that samples `sync_in` high. The same edge restarts the word phase.
- R6: After an accepted sync edge, or after the last standby cycle, `data_ready` stays at its idle level for BLANK_LEN cycles. It takes the ready level exactly BLANK_LEN cycles after that event.
- R7: Once the blanking window has ended, `data_ready` shows the ready level for exactly one cycle in each cycle that carries a `word_strobe`. In all other cycles it shows the idle level.
- R8: A sync edge accepted while a blanking window is running restarts the full BLANK_LEN window.
- R9: A rise of `sync_in` that is detected while standby is requested is ignored: no `filter_rst` pulse is produced and the word phase does not change.
- R10: While `rst` is high, `data_ready` is at the idle level for the current mode, `clk_en` is 1, and `word_strobe` and `filter_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial | input | 1 | 1 selects serial interface mode, 0 selects parallel |
| standby_pin | input | 1 | Standby request used in serial mode |
| standby_cfg | input | 1 | Standby configuration bit used in parallel mode |
| sync_in | input | 1 | Synchronization request, acted on at its rising edge |
| data_ready | output | 1 | Data-ready flag with mode-dependent levels |
| filter_rst | output | 1 | One-cycle reset pulse to the decimation filter |
| clk_en | output | 1 | Clock enable for modulator and filter |
| word_strobe | output | 1 | One-cycle marker of each output word |

## Verification
The assertions assume that `mode_serial` changes only while `rst` is high, so that the idle level of `data_ready` compared in one cycle is the one chosen in the cycle before. They also assume that `sync_in` stays low for at least one sampled cycle between pulses, so that each rise is a distinct edge. The stimulus sets the mode only during reset and always releases sync before raising it again. It sweeps the gap between sync pulses across every word phase, both inside and outside the blanking window. It raises sync in the middle of standby, and it drives the standby source of the unselected mode high while the selected one is low.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
  typedef enum logic {
    IF_PARALLEL = 1'b0,
    IF_SERIAL   = 1'b1
  } if_mode_e;

  // level data-ready rests at when no new word is being announced
  function automatic logic idle_level(if_mode_e m);
    return (m == IF_PARALLEL) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/cvr_sync_edge.sv
module cvr_sync_edge #(
  parameter int FLOPS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic [FLOPS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[FLOPS-2:0], sig};
  end

  assign rise = sh[FLOPS-2] & ~sh[FLOPS-1];
endmodule

// File: rtl/cvr_word_ctr.sv
module cvr_word_ctr #(
  parameter int WORD_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic clear,
  output logic wrap
);
  localparam int WW = (WORD_LEN > 2) ? $clog2(WORD_LEN) : 1;
  localparam logic [WW-1:0] LAST = WW'(WORD_LEN - 1);

  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold || clear) cnt <= '0;
    else if (cnt == LAST)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign wrap = (cnt == LAST);
endmodule

// File: rtl/cvr_blank_timer.sv
module cvr_blank_timer #(
  parameter int BLANK_LEN = 2080
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic last,
  output logic idle,
  output logic busy_long
);
  localparam int BW = $clog2(BLANK_LEN + 1);
  localparam logic [BW-1:0] FULL = BW'(BLANK_LEN);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)      cnt <= FULL;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last      = (cnt == BW'(1));
  assign idle      = (cnt == '0);
  assign busy_long = (cnt > BW'(1));

  // R6
  timer_settles_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !load) |=> idle);
endmodule

// File: rtl/cvr_ready_seq.sv
module cvr_ready_seq #(
  parameter int WORD_LEN   = 32,
  parameter int BLANK_LEN  = 2080,
  parameter int SYNC_FLOPS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_serial,
  input  logic standby_pin,
  input  logic standby_cfg,
  input  logic sync_in,
  output logic data_ready,
  output logic filter_rst,
  output logic clk_en,
  output logic word_strobe
);
  import cvr_pkg::*;

  if_mode_e mode;
  logic     stby_req;
  logic     sync_rise;
  logic     sync_hit;
  logic     wrap;
  logic     blank_last;
  logic     blank_idle;
  logic     blank_long;
  logic     announce;

  assign mode     = if_mode_e'(mode_serial);
  assign stby_req = (mode == IF_SERIAL) ? standby_pin : standby_cfg;
  assign sync_hit = sync_rise & ~stby_req;

  cvr_sync_edge #(.FLOPS(SYNC_FLOPS)) u_sync (
    .clk(clk), .rst(rst), .sig(sync_in), .rise(sync_rise)
  );

  cvr_word_ctr #(.WORD_LEN(WORD_LEN)) u_word (
    .clk(clk), .rst(rst), .hold(stby_req), .clear(sync_hit), .wrap(wrap)
  );

  cvr_blank_timer #(.BLANK_LEN(BLANK_LEN)) u_blank (
    .clk(clk), .rst(rst), .load(stby_req | sync_hit),
    .last(blank_last), .idle(blank_idle), .busy_long(blank_long)
  );

  assign announce = ~stby_req & ~sync_hit & (blank_last | (blank_idle & wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en      <= 1'b1;
      filter_rst  <= 1'b0;
      word_strobe <= 1'b0;
      data_ready  <= idle_level(mode);
    end else begin
      clk_en      <= ~stby_req;
      filter_rst  <= sync_hit;
      word_strobe <= ~stby_req & ~sync_hit & wrap;
      data_ready  <= announce ? ~idle_level(mode) : idle_level(mode);
    end
  end

  // R3
  gated_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> !word_strobe);

  // R4
  gated_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> (data_ready != $past(mode_serial)));

  // R5
  filter_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    filter_rst |=> !filter_rst);

  // R6
  blank_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
    blank_long |=> (data_ready != $past(mode_serial)));

  // R5
  filter_blanks_chk: assert property (@(posedge clk) disable iff (rst)
    filter_rst |-> (!blank_idle && !word_strobe));

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> !word_strobe);
endmodule

// File: tb/cvr_ready_seq_bench.sv
module cvr_ready_seq_bench;
  localparam int W  = 8;
  localparam int B  = 36;
  localparam int SF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_serial = 1'b0;
  logic standby_pin = 1'b0;
  logic standby_cfg = 1'b0;
  logic sync_in = 1'b0;
  logic data_ready, filter_rst, clk_en, word_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cvr_ready_seq #(.WORD_LEN(W), .BLANK_LEN(B), .SYNC_FLOPS(SF)) u_cvr_ready_seq (
    .clk(clk), .rst(rst), .mode_serial(mode_serial), .standby_pin(standby_pin),
    .standby_cfg(standby_cfg), .sync_in(sync_in), .data_ready(data_ready),
    .filter_rst(filter_rst), .clk_en(clk_en), .word_strobe(word_strobe)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (mode_serial=%b, t=%0t)",
               tag, act, exp, mode_serial, $time);
    end
  endtask

  // ready level expected d cycles after the phase/blank restart
  function automatic logic rdy_at(int d);
    return (d >= B) && ((d == B) || (d % W == 0));
  endfunction

  function automatic logic lvl(logic ready);
    return mode_serial ? ready : ~ready;
  endfunction

  task automatic set_stby(logic v);
    if (mode_serial) standby_pin = v;
    else             standby_cfg = v;
  endtask

  task automatic do_sync(int len, bit restart);
    sync_in = 1'b1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (n >= SF) begin
        int d;
        d = n - SF;
        chk("R5 filter_rst", filter_rst, d == 0);
        chk("R1 word_strobe", word_strobe, (d > 0) && (d % W == 0));
        chk(restart ? "R8 data_ready" : ((d == B) ? "R6 data_ready" : "R7 data_ready"),
            data_ready, lvl(rdy_at(d)));
        chk("R2 clk_en", clk_en, 1'b1);
      end
      if (n == 3) sync_in = 1'b0;
    end
  endtask

  task automatic do_standby(int hold);
    set_stby(1'b1);
    for (int n = 1; n <= hold + B + 2 * W; n++) begin
      @(negedge clk);
      if (n <= hold) begin
        chk("R3 clk_en low", clk_en, 1'b0);
        chk("R3 word_strobe", word_strobe, 1'b0);
        chk("R4 data_ready idle", data_ready, lvl(1'b0));
        chk("R9 filter_rst", filter_rst, 1'b0);
      end else begin
        int d;
        d = n - hold;
        chk("R3 clk_en high", clk_en, 1'b1);
        chk("R9 filter_rst", filter_rst, 1'b0);
        chk("R1 word_strobe", word_strobe, d % W == 0);
        chk("R6 data_ready", data_ready, lvl(rdy_at(d)));
      end
      if (n == 2) sync_in = 1'b1;
      if (n == 4) sync_in = 1'b0;
      if (n == hold) set_stby(1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      int prev;
      rst = 1'b1;
      mode_serial = m[0];
      standby_pin = 1'b0;
      standby_cfg = 1'b0;
      sync_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 data_ready", data_ready, lvl(1'b0));
      chk("R10 clk_en", clk_en, 1'b1);
      chk("R10 word_strobe", word_strobe, 1'b0);
      chk("R10 filter_rst", filter_rst, 1'b0);
      rst = 1'b0;
      do_sync(SF + B + 2 * W, 1'b0);
      prev = SF + B + 2 * W;
      for (int len = 4; len <= B + W; len++) begin
        do_sync(len, prev < SF + B);
        prev = len;
      end
      // unselected standby source held high: must change nothing (R2)
      if (mode_serial) standby_cfg = 1'b1;
      else             standby_pin = 1'b1;
      do_sync(SF + B + 2 * W, prev < SF + B);
      standby_cfg = 1'b0;
      standby_pin = 1'b0;
      do_standby(5);
      do_standby(9);
      do_sync(SF + B + 2 * W, 1'b0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule